// File: doc/BRIEF.md
# Indirect Status and Interrupt Register Bank

This block is a host-facing bank of control and status registers that sits beside a network controller. The host never addresses a register directly: it first loads an index into a pointer, and every later access through the data port reads or writes whichever register that pointer selects. The pointer keeps its value across data-port accesses, so the host can load it once and then touch the same register as often as it likes.

The main status register holds three sticky error flags: collision error, missed frame and memory error. They are set by single-cycle event pulses from the datapath and cleared by the host writing a one to the flag's bit. Because writing a zero leaves a flag alone, the host can read the status word and write the same value back to clear exactly the flags it saw. A read-only summary bit is the OR of the three flags. Missed frame and memory error can drive an active-low level interrupt when the interrupt enable is set and their mask bits are clear. Collision error is never an interrupt source. A saturating missed-frame counter, a mask register and a bus-timeout setting complete the bank.

Top module: `ctl_stat_bank`

## Requirements
- R1: A pointer write loads `wdata[PTR_W-1:0]`. From the next cycle `rdata` shows the register selected by the pointer: index 0 status, 1 mask, 2 missed-frame counter, 3 bus timeout. Any other index reads zero and ignores writes. A data-port write in the same cycle as a pointer write goes to the old index.
- R2: The pointer is cleared by hardware reset (`rst_n` low) and by `sw_rst`. It keeps its value when the stop bit is set and across all data-port accesses.
- R3: In the status register, writing 1 to bit 13 (collision error), bit 12 (missed frame) or bit 11 (memory error) clears that flag. Writing 0 leaves it unchanged.
- R4: Status bit 15 reads as the OR of bits 13, 12 and 11 and ignores writes. Status bit 14 and bits 31..16 of every register read zero.
- R5: Each `ev_miss` pulse sets the missed-frame flag and increments the 16-bit counter (index 2), which stops at 65535. The counter ignores data-port writes.
- R6: `irq_n` is low exactly when the enable (status bit 6) is 1 and either the missed-frame flag is set with mask bit 12 clear, or the memory-error flag is set with mask bit 11 clear. The collision flag never pulls `irq_n` low.
- R7: A status write with bit 2 = 1 sets the stop bit and clears the collision and missed-frame flags. It leaves the memory-error flag and the pointer unchanged. Status bits 6 and 2 are read/write.
- R8: `sw_rst` clears the pointer, all three flags, the counter, the enable and the stop bit. It keeps the mask and timeout registers. Hardware reset clears everything and loads the timeout with its default.
- R9: If an event pulse and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set. If `sw_rst` arrives in that cycle, the reset wins.
- R10: The bus-timeout register (index 3) is 16 bits, read/write, with a reset value of 1536. The mask register (index 1) is 16 bits, read/write, with a reset value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset pulse |
| ptr_wr | input | 1 | Load pointer from wdata |
| dp_wr | input | 1 | Write wdata to the selected register |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Contents of the selected register |
| ev_coll | input | 1 | Collision error event pulse |
| ev_miss | input | 1 | Missed frame event pulse |
| ev_merr | input | 1 | Memory error event pulse |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
Every state change lands on the clock edge that samples the stimulus. `rdata` and `irq_n` are combinational from the registers, so a flag, the pointer, the counter or the interrupt is due one edge after its cause. A read-back is due in the same cycle the pointer points at the register. The bench drives each stimulus for one cycle and lets it be taken at the edge. It then updates its own register model with the same inputs and compares `rdata` and `irq_n` 1 ns after that edge. Directed cases cover the same-cycle races, the stop clearing, the reset differences and counter saturation. Random cycles mix all operations.

// File: rtl/csrb_pkg.sv
// Package: shared register indices and bit positions for the indirect
// status register bank. Assumes a 32-bit data port.
package csrb_pkg;
    localparam int IDX_STAT = 0;
    localparam int IDX_MASK = 1;
    localparam int IDX_CNT  = 2;
    localparam int IDX_TMO  = 3;

    localparam int NFLAG    = 3;
    // flag i lives at status bit FLAG_TOP - i (coll, miss, merr)
    localparam int FLAG_TOP = 13;
    localparam int BIT_ERR  = 15;
    localparam int BIT_IEN  = 6;
    localparam int BIT_STOP = 2;

    typedef enum int {FL_COLL = 0, FL_MISS = 1, FL_MERR = 2} flag_e;
endpackage

// File: rtl/csrb_flag_cell.sv
// Module: one sticky status flag. An event sets it; the host clears it by
// write-one-to-clear, and optionally a stop command clears it. A set in the
// same cycle as a clear wins; reset wins over everything.
// Assumes synchronous active-low reset and single-cycle strobes.
module csrb_flag_cell #(
    parameter bit CLR_ON_STOP = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic set_ev,
    input  logic w1c,
    input  logic stop_cmd,
    output logic q
);
    logic clr;
    // combine the host clear sources permitted for this flag
    assign clr = w1c | (CLR_ON_STOP & stop_cmd);

    // hold the flag: reset, then set-priority, then clear
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) q <= 1'b0;
        else if (set_ev)      q <= 1'b1;
        else if (clr)         q <= 1'b0;
    end
endmodule

// File: rtl/csrb_sat_counter.sv
// Module: saturating event counter. It increments on each pulse, stops at
// all-ones and clears on either reset. Assumes one pulse per cycle at most.
module csrb_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = '1;

    // count events, holding at the top value
    always_ff @(posedge clk) begin
        if (!rst_n || clr)         q <= '0;
        else if (inc && q != MAXV) q <= q + 1'b1;
    end
endmodule

// File: rtl/csrb_irq_gate.sv
// Module: forms the active-low level interrupt from the flags, the global
// enable and the per-flag mask bits. Collision never takes part.
// Purely combinational; assumes registered inputs.
module csrb_irq_gate (
    input  logic ien,
    input  logic miss,
    input  logic merr,
    input  logic mask_miss,
    input  logic mask_merr,
    output logic irq_n
);
    // any enabled, unmasked source pulls the line low
    always_comb begin
        irq_n = !(ien && ((miss && !mask_miss) || (merr && !mask_merr)));
    end
endmodule

// File: rtl/ctl_stat_bank.sv
// Module: indirect control/status register bank. A pointer selects one of
// four registers (status, mask, missed-frame counter, bus timeout). Data-port
// writes go to the selected register, and rdata always shows it.
// Assumes synchronous active-low hardware reset and single-cycle strobes.
module ctl_stat_bank #(
    parameter int          DATA_W  = 32,
    parameter int          PTR_W   = 4,
    parameter int          CNT_W   = 16,
    parameter int          TMO_W   = 16,
    parameter int          MASK_W  = 16,
    parameter logic [15:0] TMO_RST = 16'd1536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              ptr_wr,
    input  logic              dp_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ev_coll,
    input  logic              ev_miss,
    input  logic              ev_merr,
    output logic              irq_n
);
    import csrb_pkg::*;

    logic [PTR_W-1:0]  ptr_q;
    logic [NFLAG-1:0]  flag_q;
    logic [NFLAG-1:0]  ev_vec;
    logic              ien_q, stop_q;
    logic [MASK_W-1:0] mask_q;
    logic [TMO_W-1:0]  tmo_q;
    logic [CNT_W-1:0]  miss_cnt;
    logic              wr_stat, wr_mask, wr_tmo, stop_cmd, err;
    logic [DATA_W-1:0] unused_wdata;

    assign unused_wdata = wdata;
    assign ev_vec       = {ev_merr, ev_miss, ev_coll};

    // decode data-port writes against the current pointer
    assign wr_stat  = dp_wr && (ptr_q == PTR_W'(IDX_STAT));
    assign wr_mask  = dp_wr && (ptr_q == PTR_W'(IDX_MASK));
    assign wr_tmo   = dp_wr && (ptr_q == PTR_W'(IDX_TMO));
    assign stop_cmd = wr_stat && wdata[BIT_STOP];

    // pointer register: cleared by both resets, else loaded by the host
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) ptr_q <= '0;
        else if (ptr_wr)      ptr_q <= wdata[PTR_W-1:0];
    end

    // enable and stop control bits in the status register
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            ien_q  <= 1'b0;
            stop_q <= 1'b0;
        end else if (wr_stat) begin
            ien_q  <= wdata[BIT_IEN];
            stop_q <= wdata[BIT_STOP];
        end
    end

    // mask register: survives software reset
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata[MASK_W-1:0];
    end

    // bus-timeout setting: survives software reset
    always_ff @(posedge clk) begin
        if (!rst_n)      tmo_q <= TMO_W'(TMO_RST);
        else if (wr_tmo) tmo_q <= wdata[TMO_W-1:0];
    end

    // one sticky cell per error flag; memory error ignores stop
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        csrb_flag_cell #(
            .CLR_ON_STOP(i != FL_MERR)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_rst  (sw_rst),
            .set_ev  (ev_vec[i]),
            .w1c     (wr_stat && wdata[FLAG_TOP-i]),
            .stop_cmd(stop_cmd),
            .q       (flag_q[i])
        );
    end

    csrb_sat_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sw_rst),
        .inc  (ev_miss),
        .q    (miss_cnt)
    );

    csrb_irq_gate u_irq (
        .ien      (ien_q),
        .miss     (flag_q[FL_MISS]),
        .merr     (flag_q[FL_MERR]),
        .mask_miss(mask_q[FLAG_TOP - FL_MISS]),
        .mask_merr(mask_q[FLAG_TOP - FL_MERR]),
        .irq_n    (irq_n)
    );

    // summary error bit over all flags
    assign err = |flag_q;

    // read multiplexer over the selected register
    always_comb begin
        rdata = '0;
        unique case (ptr_q)
            PTR_W'(IDX_STAT): begin
                rdata[BIT_ERR]  = err;
                for (int i = 0; i < NFLAG; i++) rdata[FLAG_TOP-i] = flag_q[i];
                rdata[BIT_IEN]  = ien_q;
                rdata[BIT_STOP] = stop_q;
            end
            PTR_W'(IDX_MASK): rdata[MASK_W-1:0] = mask_q;
            PTR_W'(IDX_CNT):  rdata[CNT_W-1:0]  = miss_cnt;
            PTR_W'(IDX_TMO):  rdata[TMO_W-1:0]  = tmo_q;
            default:          rdata = '0;
        endcase
    end
endmodule

// File: rtl/csrb_checker.sv
// Module: assertion checker for ctl_stat_bank, attached by bind.
// Assumes it sees the pointer, flags, counter and enable of the bank.
module csrb_checker #(
    parameter int PTR_W = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_rst,
    input logic             ptr_wr,
    input logic             ev_miss,
    input logic [PTR_W-1:0] ptr,
    input logic [CNT_W-1:0] cnt,
    input logic [2:0]       flags,
    input logic             ien,
    input logic             irq_n,
    input logic [31:0]      rdata
);
    assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_wr && !sw_rst) |=> $stable(ptr));

    assert_err_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == '0) |-> (rdata[15] == (|rdata[13:11]) && !rdata[14] && rdata[31:16] == '0));

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_miss && !sw_rst && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1 && !sw_rst) |=> (cnt == '1));

    assert_irq_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ien);

    assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (ptr == '0 && cnt == '0 && flags == '0));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_miss && !sw_rst) |=> flags[1]);
endmodule

bind ctl_stat_bank csrb_checker #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_rst (sw_rst),
    .ptr_wr (ptr_wr),
    .ev_miss(ev_miss),
    .ptr    (ptr_q),
    .cnt    (miss_cnt),
    .flags  (flag_q),
    .ien    (ien_q),
    .irq_n  (irq_n),
    .rdata  (rdata)
);

// File: tb/ctl_stat_bank_bench.sv
// Bench: directed corner cases plus seeded random traffic, compared with a
// register model kept in the bench.
module ctl_stat_bank_bench;
    localparam int PTR_W = 4;

    logic        clk = 1'b0;
    logic        rst_n, sw_rst, ptr_wr, dp_wr, ev_coll, ev_miss, ev_merr;
    logic [31:0] wdata, rdata;
    logic        irq_n;
    int          n_vec = 0, n_bad = 0;

    // model state
    logic [PTR_W-1:0] m_ptr;
    logic [2:0]       m_fl;     // [0] coll, [1] miss, [2] merr
    logic             m_ien, m_stop;
    logic [15:0]      m_mask, m_tmo, m_cnt;

    always #5 clk = ~clk;

    ctl_stat_bank u_ctl_stat_bank (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .ptr_wr(ptr_wr),
        .dp_wr(dp_wr), .wdata(wdata), .rdata(rdata), .ev_coll(ev_coll),
        .ev_miss(ev_miss), .ev_merr(ev_merr), .irq_n(irq_n)
    );

    function automatic logic [31:0] exp_rd();
        logic [31:0] r = '0;
        case (m_ptr)
            0: begin
                r[15] = |m_fl;
                r[13] = m_fl[0]; r[12] = m_fl[1]; r[11] = m_fl[2];
                r[6]  = m_ien;   r[2]  = m_stop;
            end
            1: r[15:0] = m_mask;
            2: r[15:0] = m_cnt;
            3: r[15:0] = m_tmo;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic exp_irq();
        return !(m_ien && ((m_fl[1] && !m_mask[12]) || (m_fl[2] && !m_mask[11])));
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ptr = '0; m_fl = '0; m_ien = 0; m_stop = 0;
        m_mask = '0; m_tmo = 16'd1536; m_cnt = '0;
    endtask

    // apply the inputs held across the last edge to the model
    task automatic model_step();
        logic       ws;
        logic [2:0] ev;
        ev = {ev_merr, ev_miss, ev_coll};
        if (sw_rst) begin
            m_ptr = '0; m_fl = '0; m_ien = 0; m_stop = 0; m_cnt = '0;
            return;
        end
        ws = dp_wr && m_ptr == 0;
        for (int i = 0; i < 3; i++) begin
            if (ev[i]) m_fl[i] = 1'b1;
            else if (ws && (wdata[13-i] || (i < 2 && wdata[2]))) m_fl[i] = 1'b0;
        end
        if (ev_miss && m_cnt != 16'hFFFF) m_cnt = m_cnt + 1'b1;
        if (ws) begin m_ien = wdata[6]; m_stop = wdata[2]; end
        if (dp_wr && m_ptr == 1) m_mask = wdata[15:0];
        if (dp_wr && m_ptr == 3) m_tmo  = wdata[15:0];
        if (ptr_wr) m_ptr = wdata[PTR_W-1:0];
    endtask

    task automatic idle();
        sw_rst = 0; ptr_wr = 0; dp_wr = 0; wdata = '0;
        ev_coll = 0; ev_miss = 0; ev_merr = 0;
    endtask

    // one clock with the current inputs, then model update and compare
    task automatic step(string tag);
        @(posedge clk); #1;
        model_step();
        idle();
        check({tag, " rdata"}, rdata, exp_rd());
        check({tag, " irq_n"}, {31'b0, irq_n}, {31'b0, exp_irq()});
    endtask

    task automatic set_ptr(int p, string tag);
        ptr_wr = 1; wdata = 32'(p); step(tag);
    endtask

    task automatic dwr(logic [31:0] d, string tag);
        dp_wr = 1; wdata = d; step(tag);
    endtask

    task automatic hw_reset();
        rst_n = 0; repeat (3) @(posedge clk); #1; rst_n = 1;
        model_reset();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle();
        void'($urandom(32'd20240611));
        hw_reset();
        // reset state R8 and timeout default R10
        check("R8 reset status", rdata, 32'h0);
        check("R8 reset irq", {31'b0, irq_n}, 32'h1);
        set_ptr(3, "R10 tmo ptr");
        check("R10 tmo default", rdata, 32'd1536);
        dwr(32'hFFFF_ABCD, "R10 tmo write");
        check("R10 tmo rw", rdata, 32'h0000_ABCD);
        // R1 selection and unmapped index
        set_ptr(1, "R1 sel mask");
        dwr(32'h0000_1234, "R1 mask write");
        check("R1 mask readback", rdata, 32'h0000_1234);
        set_ptr(7, "R1 unmapped");
        dwr(32'hFFFF_FFFF, "R1 unmapped write");
        check("R1 unmapped reads zero", rdata, 32'h0);
        set_ptr(1, "R1 back to mask");
        check("R1 unmapped write ignored", rdata, 32'h0000_1234);
        dwr(32'h0, "R10 mask clear");
        // R6: collision alone never interrupts
        set_ptr(0, "R1 sel status");
        dwr(32'h40, "R7 enable on");
        ev_coll = 1; step("R6 coll event");
        check("R4 err from coll", rdata, 32'h0000_A040);
        check("R6 coll no irq", {31'b0, irq_n}, 32'h1);
        // R6: missed frame with enable, then masked
        ev_miss = 1; step("R5 miss event");
        check("R6 miss irq", {31'b0, irq_n}, 32'h0);
        set_ptr(1, "R6 sel mask"); dwr(32'h1000, "R6 mask miss");
        check("R6 masked irq", {31'b0, irq_n}, 32'h1);
        dwr(32'h0, "R6 unmask");
        set_ptr(0, "R6 sel status");
        // R3 write-one-to-clear, zero leaves alone
        dwr(32'h1040, "R3 w1c miss");
        check("R3 miss cleared coll kept", rdata, 32'h0000_A040);
        // R4 summary bit ignores writes
        dwr(32'hFFFF_8040, "R4 write err");
        check("R4 err read-only", rdata, 32'h0000_A040);
        // R7 stop clears coll and miss, keeps merr and pointer
        ev_miss = 1; ev_merr = 1; step("R7 load flags");
        dwr(32'h44, "R7 stop");
        check("R7 stop result", rdata, 32'h0000_8844);
        check("R7 merr irq", {31'b0, irq_n}, 32'h0);
        // R9 set beats clear in the same cycle
        dwr(32'h0840, "R3 clear merr");
        ev_miss = 1; dp_wr = 1; wdata = 32'h1040; step("R9 race");
        check("R9 set wins", rdata & 32'h1000, 32'h1000);
        // R9 reset beats set
        ev_miss = 1; sw_rst = 1; step("R9 reset wins");
        check("R9 reset beats set", rdata, 32'h0);
        // R2/R8 software reset: pointer cleared, mask and tmo kept
        set_ptr(1, "R8 sel mask"); dwr(32'h0800, "R8 mask set");
        set_ptr(3, "R8 sel tmo");
        sw_rst = 1; step("R2 sw reset");
        set_ptr(3, "R8 sel tmo again");
        check("R8 tmo kept", rdata, 32'h0000_ABCD);
        set_ptr(1, "R8 sel mask again");
        check("R8 mask kept", rdata, 32'h0000_0800);
        // R5 saturation
        set_ptr(2, "R5 sel cnt");
        for (int k = 0; k < 65540; k++) begin ev_miss = 1; step("R5 count"); end
        check("R5 saturated", rdata, 32'h0000_FFFF);
        dwr(32'h0, "R5 write ignored");
        check("R5 counter read-only", rdata, 32'h0000_FFFF);
        // R2 hardware reset clears pointer
        hw_reset();
        check("R2 hw reset ptr", rdata, 32'h0);
        // random traffic, R1..R10 against the model
        for (int k = 0; k < 4000; k++) begin
            logic [3:0] op = 4'($urandom_range(0, 15));
            ev_coll = ($urandom_range(0, 7) == 0);
            ev_miss = ($urandom_range(0, 5) == 0);
            ev_merr = ($urandom_range(0, 7) == 0);
            if (op < 3) begin ptr_wr = 1; wdata = 32'($urandom_range(0, 5)); end
            else if (op < 10) begin dp_wr = 1; wdata = $urandom; end
            else if (op == 10 && $urandom_range(0, 15) == 0) sw_rst = 1;
            step("R1 R6 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule